// File: doc/BRIEF.md
# Buffered Synchronous Serial Port

This block is a byte-oriented synchronous serial port. An 8-bit shift register sits between a transmit holding buffer and a receive holding buffer. Software reaches both buffers and the control bits through a small register port. When a telegram starts, the block copies the transmit buffer into the shift register. It shifts data out most significant bit first and, at the same time, shifts the incoming line into the same register. Once the last bit has passed, it copies the assembled byte into the receive buffer. A one-cycle interrupt then marks the end of the telegram.

There are three framings: a plain 8-bit shift, a two-wire master framing that adds a ninth acknowledge period, and a two-wire framing of eight bits with no acknowledge. The shift clock comes either from an internal tick enable or from an external clock pin. In both two-wire framings the block always drives the clock itself. In continuous mode, a transmit buffer refilled before a telegram ends is taken without a gap, so telegrams can run back to back.

Top module: `sync_serial_port`

## Requirements
- R1: Register address 0 is the transmit buffer, which reads back as written. A write there clears status bit 0 (transmit empty). Address 1 returns the receive buffer. Address 2 holds control: bits 1:0 select the framing, bit 2 selects the external clock, bit 3 selects transmit direction, bit 4 selects continuous mode, and bit 5 is a start strobe. Address 3 is status: bit 0 transmit empty, bit 1 receive full, bit 2 sampled acknowledge level, bit 3 busy.
- R2: A start strobe while idle loads the transmit buffer into the shift register and sets status bit 0. It uses the control values written in the same write. With the internal clock, `sck_out` toggles once per `int_tick` during a telegram and rests low when idle.
- R3: Data leaves most significant bit first. `sd_out` changes only on falling shift-clock edges. `sd_in` is captured on rising edges.
- R4: After the final bit period, the received byte is copied into the receive buffer, status bit 1 is set, and `irq` pulses high for exactly one cycle. Reading address 1 clears status bit 1.
- R5: In continuous mode (control bit 4), a transmit buffer written during a telegram is loaded when that telegram ends, with no idle tick: interrupts come 2×8 ticks apart. If the buffer is empty at the end, shifting stops, status bit 3 clears and `sck_out` stays low.
- R6: Framing code 1 adds a ninth bit period. When transmitting, the block releases `sd_oe` for that period and stores the sampled line level in status bit 2.
- R7: With framing code 1 in receive direction, the ninth bit period drives `sd_out` low with `sd_oe` high.
- R8: With framing code 0 and control bit 2 set, `sck_oe` is low and synchronized `sck_in` edges move the data. With framing codes 1 or 2, control bit 2 is ignored: `sck_oe` stays high and `int_tick` clocks the transfer.
- R9: `sd_oe` is high during the data bits only when transmit direction (control bit 3 = 1) is selected, and it is low whenever the port is idle.
- R10: After reset, status reads 0x01, control reads 0, and `sck_out`, `sd_oe` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears receive full on address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| int_tick | input | 1 | Internal shift-clock enable, one toggle per pulse |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Driven shift clock |
| sck_oe | output | 1 | Shift-clock pin output enable |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Serial data pin output enable |
| irq | output | 1 | End-of-telegram pulse |

## Verification
The hardest condition to reach is the seamless hand-over between telegrams in continuous mode. The transmit buffer has to be refilled after the first byte has been taken but before its last falling edge. The bench writes the second byte straight after the start strobe and then counts cycles between the two interrupt pulses. A serial peer model in the bench follows the clock pin, external or driven, to feed bits and acknowledge levels and to capture what the port sends.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT8  = 2'd0,
        MODE_ACK9    = 2'd1,
        MODE_NOACK8  = 2'd2,
        MODE_RSVD    = 2'd3
    } ssp_mode_e;

    localparam int REG_ADDR_W = 2;
    localparam logic [REG_ADDR_W-1:0] ADDR_TX   = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_RX   = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd3;

    localparam int CTL_MODE_LO = 0;
    localparam int CTL_EXT     = 2;
    localparam int CTL_DIR     = 3;
    localparam int CTL_CONT    = 4;
    localparam int CTL_GO      = 5;

    localparam int ST_TX_EMPTY = 0;
    localparam int ST_RX_FULL  = 1;
    localparam int ST_ACK      = 2;
    localparam int ST_BUSY     = 3;
endpackage

// File: rtl/ssp_clk_edges.sv
module ssp_clk_edges #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_ext,
    input  logic active,
    input  logic int_tick,
    input  logic sck_in,
    output logic rise,
    output logic fall,
    output logic sck_out,
    output logic sck_oe
);
    typedef struct packed {
        logic [SYNC_STAGES:0] sync;
        logic                 sck;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic ext_rise, ext_fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-1:0], sck_in};
        if (!active || use_ext) begin
            st_d.sck = 1'b0;
        end else if (int_tick) begin
            st_d.sck = !st_q.sck;
        end
        ext_rise = st_q.sync[SYNC_STAGES-1] && !st_q.sync[SYNC_STAGES];
        ext_fall = !st_q.sync[SYNC_STAGES-1] && st_q.sync[SYNC_STAGES];
        rise     = active && (use_ext ? ext_rise : (int_tick && !st_q.sck));
        fall     = active && (use_ext ? ext_fall : (int_tick && st_q.sck));
        sck_out  = st_q.sck;
        sck_oe   = !use_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssp_shift_engine.sv
module ssp_shift_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cont,
    input  logic              ack_mode,
    input  logic              tx_dir,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_avail,
    input  logic              rise,
    input  logic              fall,
    input  logic              sd_in,
    output logic              busy,
    output logic              take_tx,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              ack_level,
    output logic              sd_out,
    output logic              sd_oe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ACK_IDX   = CNT_W'(DATA_W);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              obit;
        logic              ack;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic in_ack;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        st_d     = st_q;
        take_tx  = 1'b0;
        done     = 1'b0;
        last_idx = ack_mode ? ACK_IDX : LAST_DATA;
        in_ack   = ack_mode && (st_q.cnt == ACK_IDX);
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.cnt   = '0;
                st_d.shreg = tx_data;
                st_d.obit  = tx_data[DATA_W-1];
                take_tx    = 1'b1;
            end
        end else begin
            if (rise) begin
                if (in_ack) begin
                    if (tx_dir) st_d.ack = sd_in;
                end else begin
                    st_d.shreg = {st_q.shreg[DATA_W-2:0], sd_in};
                end
            end
            if (fall) begin
                if (st_q.cnt == last_idx) begin
                    done     = 1'b1;
                    st_d.cnt = '0;
                    if (cont && tx_avail) begin
                        st_d.shreg = tx_data;
                        st_d.obit  = tx_data[DATA_W-1];
                        take_tx    = 1'b1;
                    end else begin
                        st_d.busy = 1'b0;
                    end
                end else begin
                    st_d.cnt  = st_q.cnt + 1'b1;
                    st_d.obit = st_q.shreg[DATA_W-1];
                end
            end
        end
        busy      = st_q.busy;
        rx_data   = st_q.shreg;
        ack_level = st_q.ack;
        sd_out    = !st_q.busy ? 1'b1 : (in_ack ? 1'b0 : st_q.obit);
        sd_oe     = st_q.busy && (in_ack ? !tx_dir : tx_dir);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  int_tick,
    input  logic                  sck_in,
    output logic                  sck_out,
    output logic                  sck_oe,
    input  logic                  sd_in,
    output logic                  sd_out,
    output logic                  sd_oe,
    output logic                  irq
);
    typedef struct packed {
        logic [DATA_W-1:0] tx_buf;
        logic              tx_full;
        logic [DATA_W-1:0] rx_buf;
        logic              rx_full;
        ssp_mode_e         mode;
        logic              ext_sel;
        logic              tx_dir;
        logic              cont;
        logic              irq;
    } port_st_t;

    port_st_t st_d, st_q;

    logic              wr_tx, wr_ctl, rd_rx, go;
    ssp_mode_e         mode_eff;
    logic              ext_eff, dir_eff, cont_eff, two_wire_eff, use_ext;
    logic              eng_busy, take_tx, tel_done, eng_ack;
    logic [DATA_W-1:0] eng_rx;
    logic              sh_rise, sh_fall;

    always_comb begin
        wr_tx  = reg_wr && (reg_addr == ADDR_TX);
        wr_ctl = reg_wr && (reg_addr == ADDR_CTRL);
        rd_rx  = reg_rd && (reg_addr == ADDR_RX);
        go     = wr_ctl && reg_wdata[CTL_GO];
        if (wr_ctl) begin
            mode_eff = ssp_mode_e'(reg_wdata[CTL_MODE_LO +: 2]);
            ext_eff  = reg_wdata[CTL_EXT];
            dir_eff  = reg_wdata[CTL_DIR];
            cont_eff = reg_wdata[CTL_CONT];
        end else begin
            mode_eff = st_q.mode;
            ext_eff  = st_q.ext_sel;
            dir_eff  = st_q.tx_dir;
            cont_eff = st_q.cont;
        end
        two_wire_eff = (mode_eff == MODE_ACK9) || (mode_eff == MODE_NOACK8);
        use_ext      = ext_eff && !two_wire_eff;
    end

    ssp_clk_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_ext  (use_ext),
        .active   (eng_busy),
        .int_tick (int_tick),
        .sck_in   (sck_in),
        .rise     (sh_rise),
        .fall     (sh_fall),
        .sck_out  (sck_out),
        .sck_oe   (sck_oe)
    );

    ssp_shift_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go),
        .cont      (cont_eff),
        .ack_mode  (mode_eff == MODE_ACK9),
        .tx_dir    (dir_eff),
        .tx_data   (st_q.tx_buf),
        .tx_avail  (st_q.tx_full),
        .rise      (sh_rise),
        .fall      (sh_fall),
        .sd_in     (sd_in),
        .busy      (eng_busy),
        .take_tx   (take_tx),
        .done      (tel_done),
        .rx_data   (eng_rx),
        .ack_level (eng_ack),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = tel_done;
        if (take_tx) st_d.tx_full = 1'b0;
        if (wr_tx) begin
            st_d.tx_buf  = reg_wdata;
            st_d.tx_full = 1'b1;
        end
        if (rd_rx) st_d.rx_full = 1'b0;
        if (tel_done) begin
            st_d.rx_buf  = eng_rx;
            st_d.rx_full = 1'b1;
        end
        if (wr_ctl) begin
            st_d.mode    = mode_eff;
            st_d.ext_sel = ext_eff;
            st_d.tx_dir  = dir_eff;
            st_d.cont    = cont_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_TX: reg_rdata = st_q.tx_buf;
            ADDR_RX: reg_rdata = st_q.rx_buf;
            ADDR_CTRL: begin
                reg_rdata[CTL_MODE_LO +: 2] = st_q.mode;
                reg_rdata[CTL_EXT]          = st_q.ext_sel;
                reg_rdata[CTL_DIR]          = st_q.tx_dir;
                reg_rdata[CTL_CONT]         = st_q.cont;
            end
            default: begin
                reg_rdata[ST_TX_EMPTY] = !st_q.tx_full;
                reg_rdata[ST_RX_FULL]  = st_q.rx_full;
                reg_rdata[ST_ACK]      = eng_ack;
                reg_rdata[ST_BUSY]     = eng_busy;
            end
        endcase
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic sck_out,
    input logic sck_oe,
    input logic sd_out,
    input logic sd_oe,
    input logic busy,
    input logic rx_full,
    input logic two_wire
);
    // R4: end-of-telegram pulse lasts one cycle
    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4: pulse coincides with a filled receive buffer
    a_r4_rx_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_full);

    // R9: data pin released while idle
    a_r9_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sd_oe);

    // R2: clock rests low while idle
    a_r2_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_out);

    // R3: output bit does not move on a rising clock edge
    a_r3_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_out) |-> $stable(sd_out));

    // R8: two-wire framings always drive the clock
    a_r8_master_clock: assert property (@(posedge clk) disable iff (!rst_n)
        two_wire |-> sck_oe);
endmodule

bind sync_serial_port ssp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .sck_out  (sck_out),
    .sck_oe   (sck_oe),
    .sd_out   (sd_out),
    .sd_oe    (sd_oe),
    .busy     (eng_busy),
    .rx_full  (st_q.rx_full),
    .two_wire (two_wire_eff)
);

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       int_tick = 1'b1;
    logic       sck_in = 1'b0;
    logic       sck_out, sck_oe;
    logic       sd_in = 1'b1;
    logic       sd_out, sd_oe, irq;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // peer model state
    logic [7:0] peer_byte = 8'd0, cap_byte = 8'd0;
    logic       peer_ack = 1'b1, peer_ext = 1'b0, gen_on = 1'b0;
    logic       pclk, pclk_prev = 1'b0;
    logic       oe_any = 1'b0, oe_all = 1'b1, ack_out = 1'b1, ack_oe = 1'b0;
    int         pidx = 0, plen = 8, gen_cnt = 0;

    // {mode[1:0], dir, tx[7:0], peer[7:0], ack}
    localparam logic [19:0] VEC [7] = '{
        {2'd0, 1'b1, 8'hA5, 8'h3C, 1'b0},
        {2'd0, 1'b0, 8'h00, 8'hC3, 1'b0},
        {2'd1, 1'b1, 8'h81, 8'h7E, 1'b0},
        {2'd1, 1'b1, 8'h6D, 8'h12, 1'b1},
        {2'd1, 1'b0, 8'hFF, 8'hB4, 1'b1},
        {2'd2, 1'b1, 8'h5A, 8'hE1, 1'b0},
        {2'd2, 1'b0, 8'h0F, 8'h96, 1'b0}
    };

    sync_serial_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_tick(int_tick), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (gen_on) begin
            gen_cnt = gen_cnt + 1;
            if (gen_cnt == 6) begin
                gen_cnt = 0;
                sck_in = ~sck_in;
            end
        end
        pclk = peer_ext ? sck_in : sck_out;
        if (pclk && !pclk_prev) begin
            if (pidx < 8) begin
                cap_byte = {cap_byte[6:0], sd_out};
                if (sd_oe) oe_any = 1'b1; else oe_all = 1'b0;
            end else begin
                ack_out = sd_out;
                ack_oe  = sd_oe;
            end
        end
        if (!pclk && pclk_prev) pidx = (pidx + 1 == plen) ? 0 : pidx + 1;
        sd_in = (pidx < 8) ? peer_byte[7 - pidx] : peer_ack;
        pclk_prev = pclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic start_xfer(input logic [1:0] mode, input logic dir, input logic ext,
                              input logic cont, input logic [7:0] tx,
                              input logic [7:0] peer, input logic ack);
        peer_byte = peer; peer_ack = ack; plen = (mode == 2'd1) ? 9 : 8;
        pidx = 0; cap_byte = 8'd0; oe_any = 1'b0; oe_all = 1'b1;
        ack_out = 1'b1; ack_oe = 1'b0;
        peer_ext = ext && (mode == 2'd0);
        sd_in = peer[7];
        wr(2'd0, tx);
        wr(2'd2, {2'b00, 1'b1, cont, dir, ext, mode});
        gen_cnt = 0; gen_on = peer_ext;
    endtask

    task automatic wait_irq(input string req, output int cyc);
        cyc = 0;
        while (!irq && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        gen_on = 1'b0;
        if (!irq) chk(req, 32'd0, 32'd1);
    endtask

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 sck_out", sck_out, 0);
        chk("R10 sd_oe", sd_oe, 0);
        chk("R10 irq", irq, 0);
        rd(2'd3, d); chk("R10 status", d, 8'h01);
        rd(2'd2, d); chk("R10 control", d, 8'h00);

        // R1 transmit buffer access
        wr(2'd0, 8'h5A);
        rd(2'd0, d); chk("R1 tx readback", d, 8'h5A);
        rd(2'd3, d); chk("R1 tx empty cleared", d[0], 0);

        // table walk
        for (int i = 0; i < 7; i++) begin
            logic [1:0] m; logic dr; logic [7:0] tx, pb; logic ak;
            {m, dr, tx, pb, ak} = VEC[i];
            start_xfer(m, dr, 1'b0, 1'b0, tx, pb, ak);
            rd(2'd3, d); chk("R2 tx empty after start", d[0], 1);
            wait_irq("R4 irq seen", n);
            @(negedge clk);
            chk("R4 irq one cycle", irq, 0);
            rd(2'd3, d); chk("R4 rx full set", d[1], 1);
            rd(2'd1, d); chk("R3 rx byte msb first", d, pb);
            rd(2'd3, d); chk("R4 rx full cleared by read", d[1], 0);
            if (dr) begin
                chk("R3 tx byte msb first", cap_byte, tx);
                chk("R9 oe during tx data", oe_all, 1);
            end else begin
                chk("R9 no oe in receive", oe_any, 0);
            end
            if (m == 2'd1 && dr) begin
                chk("R6 ack released", ack_oe, 0);
                rd(2'd3, d); chk("R6 ack sampled", d[2], ak);
            end
            if (m == 2'd1 && !dr) begin
                chk("R7 ack driven low", {ack_oe, ack_out}, 2'b10);
            end
        end

        // R5 continuous back-to-back telegrams
        start_xfer(2'd0, 1'b1, 1'b0, 1'b1, 8'h3C, 8'h69, 1'b0);
        wr(2'd0, 8'hC7);
        wait_irq("R5 first irq", n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 100);
        chk("R5 no idle gap", n, 16);
        chk("R5 second byte sent", cap_byte, 8'hC7);
        rd(2'd1, d); chk("R5 second byte received", d, 8'h69);
        repeat (4) @(negedge clk);
        rd(2'd3, d); chk("R5 stopped when empty", d[3], 0);
        chk("R5 clock idle", sck_out, 0);
        chk("R5 tx empty", d[0], 1);

        // R8 external clock in plain framing
        start_xfer(2'd0, 1'b1, 1'b1, 1'b0, 8'h96, 8'h2B, 1'b0);
        chk("R8 clock pin released", sck_oe, 0);
        wait_irq("R8 external irq", n);
        chk("R8 external tx", cap_byte, 8'h96);
        rd(2'd1, d); chk("R8 external rx", d, 8'h2B);

        // R8 external request ignored in two-wire framing
        start_xfer(2'd2, 1'b1, 1'b1, 1'b0, 8'hE4, 8'h71, 1'b0);
        chk("R8 two-wire drives clock", sck_oe, 1);
        wait_irq("R8 two-wire irq", n);
        chk("R8 two-wire tx", cap_byte, 8'hE4);
        rd(2'd1, d); chk("R8 two-wire rx", d, 8'h71);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL all requirements watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule